// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Burst Address Counters

This block is a two-port synchronous memory of 9-bit words. Each side has its own clock, two chip selects, a write/read control, an output-enable and a read-latency mode. Either side can read or write any word at any time, and the two sides can even touch the same word in the same cycle. Each side keeps its own address register, which works as a burst counter. The counter can be cleared, loaded from the address pins or stepped by one. A run of sequential accesses therefore needs only one external address.

On each clock edge a selected side first forms its access address. A clear gives zero. Otherwise a strobe gives the address pins. Otherwise a count enable gives the old counter plus one. Otherwise the old counter is kept. The side accesses that address on the same edge and keeps it as the new counter value. Read data comes out one edge later in flow-through mode, or two edges later in pipelined mode. The data bus is returned as a data vector plus a drive enable, so the chip-level pad ring owns the tristate.

The address width is the `AW` parameter. Production builds use 13 or 14 bits (8K or 16K words). The default is kept small.

Top module: `dpr_sync_ram`

## Requirements
- R1: With the mode input low (flow-through), a read accessed on edge k presents the addressed word on the data output after edge k.
- R2: With the mode input high (pipelined), a read accessed on edge k presents its word after edge k+1.
- R3: The drive output is 1 only when the output-enable input is 1 and a selected read is due at the output for the current mode. It is 0 after reset.
- R4: A port is selected only when its active-low chip enable is 0 and its active-high chip enable is 1. A deselected port writes nothing and its counter holds, whatever its counter controls are doing.
- R5: When selected, the counter obeys clear first, then load from the address pins, then increment by one. The resulting value is the address accessed on that same edge.
- R6: Incrementing from the top address (all ones) gives address zero.
- R7: When both ports write the same word on the same edge, the left port's data is the value stored.
- R8: A read that accesses a word on the same edge that the other port writes it returns the contents from before that write.
- R9: Both ports can read the same word on the same edge, and each returns it under its own latency mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of counters, output stages and word ownership |
| clk_l_i | input | 1 | Left port clock |
| ce0_l_ni | input | 1 | Left chip enable, active low |
| ce1_l_i | input | 1 | Left chip enable, active high |
| we_l_i | input | 1 | Left access type: 1 write, 0 read |
| oe_l_i | input | 1 | Left output enable, active high |
| pipe_l_i | input | 1 | Left latency mode: 0 flow-through, 1 pipelined |
| ads_l_i | input | 1 | Left address strobe: load the counter from addr_l_i |
| cnten_l_i | input | 1 | Left count enable: increment the counter |
| cntrst_l_i | input | 1 | Left counter clear |
| addr_l_i | input | AW | Left external address |
| wdata_l_i | input | DW | Left write data |
| rdata_l_o | output | DW | Left read data |
| drive_l_o | output | 1 | Left data bus drive enable |
| clk_r_i | input | 1 | Right port clock |
| ce0_r_ni | input | 1 | Right chip enable, active low |
| ce1_r_i | input | 1 | Right chip enable, active high |
| we_r_i | input | 1 | Right access type: 1 write, 0 read |
| oe_r_i | input | 1 | Right output enable, active high |
| pipe_r_i | input | 1 | Right latency mode: 0 flow-through, 1 pipelined |
| ads_r_i | input | 1 | Right address strobe |
| cnten_r_i | input | 1 | Right count enable |
| cntrst_r_i | input | 1 | Right counter clear |
| addr_r_i | input | AW | Right external address |
| wdata_r_i | input | DW | Right write data |
| rdata_r_o | output | DW | Right read data |
| drive_r_o | output | 1 | Right data bus drive enable |

## Verification
The counter cannot be seen directly. A wrong counter value shows up as a wrong word on the next read from that port: one edge later in flow-through mode and two in pipelined mode. Because every word is preloaded with a distinct pattern, any address error is caught on the first read that follows it. A wrong ownership bit for a word shows up as stale data the next time that word is read from either side. A wrong output-stage valid flag shows up at once on the drive enable.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

  function automatic logic port_sel(input logic ce0_n, input logic ce1);
    return !ce0_n && ce1;
  endfunction
endpackage

// File: rtl/dpr_addr_ctr.sv
`timescale 1ns/1ps
module dpr_addr_ctr #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          ads_i,
  input  logic          cnten_i,
  input  logic          cntrst_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_o,
  output logic [AW-1:0] cnt_o
);
  logic [AW-1:0] cnt_q;

  // address used on this edge; also the next counter value
  always_comb begin
    eff_o = cnt_q;
    if (sel_i) begin
      if (cntrst_i)     eff_o = '0;
      else if (ads_i)   eff_o = addr_i;
      else if (cnten_i) eff_o = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= eff_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dpr_lvt_mem.sv
`timescale 1ns/1ps
module dpr_lvt_mem #(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          clk_l_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          wr_l_i,
  input  logic [AW-1:0] addr_l_i,
  input  logic [DW-1:0] wdata_l_i,
  input  logic          wr_r_i,
  input  logic [AW-1:0] addr_r_i,
  input  logic [DW-1:0] wdata_r_i,
  output logic [DW-1:0] word_l_o,
  output logic [DW-1:0] word_r_o
);
  localparam int DEPTH = 1 << AW;

  // one bank per writer; tag_l ^ tag_r selects the live bank per word
  logic [DW-1:0]    bank_l [DEPTH];
  logic [DW-1:0]    bank_r [DEPTH];
  logic [DEPTH-1:0] tag_l, tag_r;
  logic             r_lose;

  // same-edge write to one word: left wins, right write dropped
  assign r_lose = wr_l_i && wr_r_i && (addr_l_i == addr_r_i);

  always_ff @(posedge clk_l_i) begin
    if (wr_l_i) bank_l[addr_l_i] <= wdata_l_i;
  end

  always_ff @(posedge clk_l_i or negedge rst_ni) begin
    if (!rst_ni)     tag_l <= '0;
    else if (wr_l_i) tag_l[addr_l_i] <= tag_r[addr_l_i];
  end

  always_ff @(posedge clk_r_i) begin
    if (wr_r_i && !r_lose) bank_r[addr_r_i] <= wdata_r_i;
  end

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)                tag_r <= '0;
    else if (wr_r_i && !r_lose) tag_r[addr_r_i] <= ~tag_l[addr_r_i];
  end

  assign word_l_o = (tag_l[addr_l_i] ^ tag_r[addr_l_i]) ? bank_r[addr_l_i] : bank_l[addr_l_i];
  assign word_r_o = (tag_l[addr_r_i] ^ tag_r[addr_r_i]) ? bank_r[addr_r_i] : bank_l[addr_r_i];
endmodule

// File: rtl/dpr_rd_pipe.sv
`timescale 1ns/1ps
module dpr_rd_pipe
  import dpr_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] word_i,
  input  logic          oe_i,
  input  logic          mode_i,
  output logic [DW-1:0] data_o,
  output logic          drive_o
);
  logic [DW-1:0] s1_dat, s2_dat;
  logic          s1_vld, s2_vld;
  lat_mode_e     mode;

  assign mode = lat_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_dat <= '0;
      s2_dat <= '0;
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      if (fire_i) s1_dat <= word_i;
      s1_vld <= fire_i;
      s2_dat <= s1_dat;
      s2_vld <= s1_vld;
    end
  end

  assign data_o  = (mode == LAT_PIPE) ? s2_dat : s1_dat;
  assign drive_o = oe_i && ((mode == LAT_PIPE) ? s2_vld : s1_vld);
endmodule

// File: rtl/dpr_sync_ram.sv
`timescale 1ns/1ps
module dpr_sync_ram
  import dpr_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          rst_ni,
  input  logic          clk_l_i,
  input  logic          ce0_l_ni,
  input  logic          ce1_l_i,
  input  logic          we_l_i,
  input  logic          oe_l_i,
  input  logic          pipe_l_i,
  input  logic          ads_l_i,
  input  logic          cnten_l_i,
  input  logic          cntrst_l_i,
  input  logic [AW-1:0] addr_l_i,
  input  logic [DW-1:0] wdata_l_i,
  output logic [DW-1:0] rdata_l_o,
  output logic          drive_l_o,
  input  logic          clk_r_i,
  input  logic          ce0_r_ni,
  input  logic          ce1_r_i,
  input  logic          we_r_i,
  input  logic          oe_r_i,
  input  logic          pipe_r_i,
  input  logic          ads_r_i,
  input  logic          cnten_r_i,
  input  logic          cntrst_r_i,
  input  logic [AW-1:0] addr_r_i,
  input  logic [DW-1:0] wdata_r_i,
  output logic [DW-1:0] rdata_r_o,
  output logic          drive_r_o
);
  logic          sel_l, sel_r;
  logic [AW-1:0] eff_l, eff_r, cnt_l, cnt_r;
  logic [DW-1:0] word_l, word_r;

  assign sel_l = port_sel(ce0_l_ni, ce1_l_i);
  assign sel_r = port_sel(ce0_r_ni, ce1_r_i);

  dpr_addr_ctr #(.AW(AW)) u_ctr_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .sel_i(sel_l), .ads_i(ads_l_i),
    .cnten_i(cnten_l_i), .cntrst_i(cntrst_l_i), .addr_i(addr_l_i),
    .eff_o(eff_l), .cnt_o(cnt_l)
  );

  dpr_addr_ctr #(.AW(AW)) u_ctr_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .sel_i(sel_r), .ads_i(ads_r_i),
    .cnten_i(cnten_r_i), .cntrst_i(cntrst_r_i), .addr_i(addr_r_i),
    .eff_o(eff_r), .cnt_o(cnt_r)
  );

  dpr_lvt_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_l_i(clk_l_i), .clk_r_i(clk_r_i), .rst_ni(rst_ni),
    .wr_l_i(sel_l && we_l_i), .addr_l_i(eff_l), .wdata_l_i(wdata_l_i),
    .wr_r_i(sel_r && we_r_i), .addr_r_i(eff_r), .wdata_r_i(wdata_r_i),
    .word_l_o(word_l), .word_r_o(word_r)
  );

  dpr_rd_pipe #(.DW(DW)) u_pipe_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .fire_i(sel_l && !we_l_i),
    .word_i(word_l), .oe_i(oe_l_i), .mode_i(pipe_l_i),
    .data_o(rdata_l_o), .drive_o(drive_l_o)
  );

  dpr_rd_pipe #(.DW(DW)) u_pipe_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .fire_i(sel_r && !we_r_i),
    .word_i(word_r), .oe_i(oe_r_i), .mode_i(pipe_r_i),
    .data_o(rdata_r_o), .drive_o(drive_r_o)
  );
endmodule

// File: rtl/dpr_port_chk.sv
`timescale 1ns/1ps
module dpr_port_chk #(
  parameter int AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce0_ni,
  input logic          ce1_i,
  input logic          we_i,
  input logic          oe_i,
  input logic          pipe_i,
  input logic          ads_i,
  input logic          cnten_i,
  input logic          cntrst_i,
  input logic [AW-1:0] addr_i,
  input logic          drive_i,
  input logic [AW-1:0] cnt_i
);
  logic sel, fire;
  assign sel  = !ce0_ni && ce1_i;
  assign fire = sel && !we_i;

  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> cnt_i == $past(cnt_i));

  assert_clear_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel && cntrst_i |=> cnt_i == '0);

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel && !cntrst_i && ads_i |=> cnt_i == $past(addr_i));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel && !cntrst_i && !ads_i && cnten_i && (cnt_i == '1) |=> cnt_i == '0);

  assert_flow_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i && !pipe_i |-> oe_i && $past(fire));

  assert_pipe_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i && pipe_i |-> oe_i && $past(fire, 2));
endmodule

bind dpr_sync_ram dpr_port_chk #(.AW(AW)) i_chk_l (
  .clk_i(clk_l_i), .rst_ni(rst_ni), .ce0_ni(ce0_l_ni), .ce1_i(ce1_l_i),
  .we_i(we_l_i), .oe_i(oe_l_i), .pipe_i(pipe_l_i), .ads_i(ads_l_i),
  .cnten_i(cnten_l_i), .cntrst_i(cntrst_l_i), .addr_i(addr_l_i),
  .drive_i(drive_l_o), .cnt_i(cnt_l)
);

bind dpr_sync_ram dpr_port_chk #(.AW(AW)) i_chk_r (
  .clk_i(clk_r_i), .rst_ni(rst_ni), .ce0_ni(ce0_r_ni), .ce1_i(ce1_r_i),
  .we_i(we_r_i), .oe_i(oe_r_i), .pipe_i(pipe_r_i), .ads_i(ads_r_i),
  .cnten_i(cnten_r_i), .cntrst_i(cntrst_r_i), .addr_i(addr_r_i),
  .drive_i(drive_r_o), .cnt_i(cnt_r)
);

// File: tb/test_dpr_sync_ram.sv
`timescale 1ns/1ps
module test_dpr_sync_ram;
  localparam int AW = 9;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          ce0n [2], ce1 [2], we [2], oe [2], pipe [2];
  logic          ads [2], cnten [2], cntrst [2];
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rdat_l, rdat_r;
  logic          drv_l, drv_r;

  dpr_sync_ram #(.AW(AW), .DW(DW)) i_dpr_sync_ram (
    .rst_ni(rst_ni),
    .clk_l_i(clk), .ce0_l_ni(ce0n[0]), .ce1_l_i(ce1[0]), .we_l_i(we[0]),
    .oe_l_i(oe[0]), .pipe_l_i(pipe[0]), .ads_l_i(ads[0]), .cnten_l_i(cnten[0]),
    .cntrst_l_i(cntrst[0]), .addr_l_i(ad[0]), .wdata_l_i(wd[0]),
    .rdata_l_o(rdat_l), .drive_l_o(drv_l),
    .clk_r_i(clk), .ce0_r_ni(ce0n[1]), .ce1_r_i(ce1[1]), .we_r_i(we[1]),
    .oe_r_i(oe[1]), .pipe_r_i(pipe[1]), .ads_r_i(ads[1]), .cnten_r_i(cnten[1]),
    .cntrst_r_i(cntrst[1]), .addr_r_i(ad[1]), .wdata_r_i(wd[1]),
    .rdata_r_o(rdat_r), .drive_r_o(drv_r)
  );

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] cnt_m [2];
  logic [DW-1:0] s1d [2], s2d [2];
  logic          s1v [2], s2v [2];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int i);
    return DW'((i * 37 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic set_port(input int p, input bit s, input bit w, input bit o,
                          input bit pm, input bit ld, input bit inc, input bit clr,
                          input int a, input int d);
    ce0n[p] = !s; ce1[p] = s; we[p] = w; oe[p] = o; pipe[p] = pm;
    ads[p] = ld; cnten[p] = inc; cntrst[p] = clr;
    ad[p] = AW'(a); wd[p] = DW'(d);
  endtask

  task automatic idle(input int p);
    set_port(p, 0, 0, 1, pipe[p], 0, 0, 0, 0, 0);
  endtask

  // one edge: model it, clock it, check outputs at the following negedge
  task automatic step(input string tag);
    logic [AW-1:0] eff [2];
    logic          sel [2];
    for (int p = 0; p < 2; p++) begin
      sel[p] = !ce0n[p] && ce1[p];
      eff[p] = cnt_m[p];
      if (sel[p]) begin
        if (cntrst[p])     eff[p] = '0;
        else if (ads[p])   eff[p] = ad[p];
        else if (cnten[p]) eff[p] = cnt_m[p] + 1'b1;
      end
      s2d[p] = s1d[p];
      s2v[p] = s1v[p];
      s1v[p] = sel[p] && !we[p];
      if (s1v[p]) s1d[p] = ref_mem[eff[p]];   // old contents (R8)
      cnt_m[p] = eff[p];
    end
    if (sel[1] && we[1]) ref_mem[eff[1]] = wd[1];
    if (sel[0] && we[0]) ref_mem[eff[0]] = wd[0];  // left wins (R7)
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      string t;
      logic  ev;
      logic [DW-1:0] ed;
      ev = oe[p] && (pipe[p] ? s2v[p] : s1v[p]);
      ed = pipe[p] ? s2d[p] : s1d[p];
      t = (tag != "") ? tag : (pipe[p] ? "R2" : "R1");
      check((tag != "") ? tag : "R3", int'(p == 0 ? drv_l : drv_r), int'(ev));
      if (ev) check(t, int'(p == 0 ? rdat_l : rdat_r), int'(ed));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    for (int p = 0; p < 2; p++) begin
      pipe[p] = 0;
      idle(p);
      cnt_m[p] = '0; s1d[p] = '0; s2d[p] = '0; s1v[p] = 0; s2v[p] = 0;
    end
    repeat (3) @(negedge clk);
    check("R3", int'(drv_l), 0);
    check("R3", int'(drv_r), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // preload through a left burst: clear, then increment (R5)
    set_port(0, 1, 1, 1, 0, 0, 0, 1, 0, pattern(0));
    step("R5");
    for (int i = 1; i < DEPTH; i++) begin
      set_port(0, 1, 1, 1, 0, 0, 1, 0, 0, pattern(i));
      step("R5");
    end
    idle(0);

    // R1 flow-through read
    set_port(0, 1, 0, 1, 0, 1, 0, 0, 3, 0); step("R1");
    idle(0); step("R1");
    // R2 pipelined read on the right
    set_port(1, 1, 0, 1, 1, 1, 0, 0, 4, 0); step("R2");
    idle(1); step("R2"); step("R2");
    pipe[1] = 0;

    // R7 both write the same word
    set_port(0, 1, 1, 1, 0, 1, 0, 0, 5, 9'h1aa);
    set_port(1, 1, 1, 1, 0, 1, 0, 0, 5, 9'h055);
    step("R7");
    set_port(0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    set_port(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7");

    // R8 right reads word 6 while left writes it
    set_port(0, 1, 1, 1, 0, 1, 0, 0, 6, 9'h0f0);
    set_port(1, 1, 0, 1, 0, 1, 0, 0, 6, 0);
    step("R8");
    // R9 both read word 6, left pipelined, right flow-through
    set_port(0, 1, 0, 1, 1, 0, 0, 0, 0, 0);
    set_port(1, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R9");
    idle(0); idle(1); step("R9");
    pipe[0] = 0;

    // R4 deselected write (ce0 low, ce1 low) is dropped
    set_port(0, 1, 0, 1, 0, 1, 0, 0, 10, 0); step("R4");
    set_port(0, 0, 1, 1, 0, 1, 1, 1, 7, 9'h133);
    ce0n[0] = 0; ce1[0] = 0;
    step("R4");
    set_port(0, 0, 1, 1, 0, 1, 1, 1, 7, 9'h133);
    ce0n[0] = 1; ce1[0] = 1;
    step("R4");
    set_port(0, 1, 0, 1, 0, 0, 0, 0, 0, 0); step("R4");   // still word 10
    set_port(0, 1, 0, 1, 0, 1, 0, 0, 7, 0); step("R4");   // word 7 unchanged

    // R5 priority
    set_port(0, 1, 0, 1, 0, 1, 1, 1, 9, 0); step("R5");   // clear wins: 0
    set_port(0, 1, 0, 1, 0, 1, 1, 0, 9, 0); step("R5");   // load wins: 9
    set_port(0, 1, 0, 1, 0, 0, 1, 0, 0, 0); step("R5");   // 10

    // R6 wrap
    set_port(0, 1, 0, 1, 0, 1, 0, 0, DEPTH - 1, 0); step("R6");
    set_port(0, 1, 0, 1, 0, 0, 1, 0, 0, 0); step("R6");
    idle(0);

    // random traffic, addresses biased low to force collisions
    for (int c = 0; c < 3000; c++) begin
      if (c % 64 == 0) begin
        pipe[0] = 1'($urandom);
        pipe[1] = 1'($urandom);
      end
      for (int p = 0; p < 2; p++) begin
        ce0n[p]   = ($urandom % 8) == 0;
        ce1[p]    = ($urandom % 8) != 0;
        we[p]     = 1'($urandom);
        oe[p]     = ($urandom % 5) != 0;
        ads[p]    = ($urandom % 3) == 0;
        cnten[p]  = 1'($urandom);
        cntrst[p] = ($urandom % 20) == 0;
        ad[p]     = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 8);
        wd[p]     = DW'($urandom);
      end
      step("");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule